// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block collects up to 64 interrupt inputs, arranged as two banks of 32, and presents them to a processor through a small register window of sixteen 32-bit words. Every input is synchronised to the block clock. A rising edge on an input whose enable bit is set is captured in that bank's latched-event register. The live synchronised state of every input is always readable, whether or not the input is enabled. Software masks and unmasks sources through a per-bank enable register that reads back exactly what was written. It clears captured events by writing ones to a per-bank acknowledge word.

One registered request line goes high while any enabled source holds a latched event. A read-only vector word gives the number of the most urgent pending source. For the vector, a source is pending when its latched event or its live level is set and the source is enabled. The upper bank wins over the lower bank, and within a bank the higher bit number wins. Enabling a source whose input is already high latches nothing and raises no request. Software that needs the request must look at the level word or the vector and act on it.

The bus is a plain single-cycle register port. `bus_addr_i` is a word index, which is the byte offset divided by four. A write takes effect on the clock edge where `bus_sel_i` and `bus_we_i` are both high. Read data is combinational from the address.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every latched-event bit and every enable bit is 0, `irq_o` is 0, and the vector word reads 0x80.
- R2: The level word of a bank returns the synchronised state of its 32 inputs, whatever the enable bits are. A change on an input is visible in the level word after two clock edges.
- R3: A rising edge on an enabled input sets its latched-event bit. The bit is readable after the third clock edge following the input change.
- R4: A rising edge on an input whose enable bit is 0 latches nothing. Setting an enable bit while the input is already high also latches nothing, and `irq_o` stays low.
- R5: Writing the acknowledge word clears every latched-event bit written as 1 and leaves the bits written as 0 unchanged. If a new edge is captured in the same cycle as an acknowledge of that bit, the edge wins and the bit stays set.
- R6: The enable word of each bank reads back exactly the last value written to it.
- R7: Writes to the latched-event word and the level word are ignored.
- R8: `irq_o` is a register that holds the OR, over both banks, of latched-event AND enable. It changes one clock edge after the register state that causes the change.
- R9: The vector word at word index 0 reads {bit 7 = 1, all other bits 0} when nothing is pending. Otherwise it reads the index of the highest-numbered pending source, where pending = (event OR level) AND enable. Sources 32–63 are therefore chosen before sources 0–31.
- R10: Sources 0–31 use the bank at word indices 8–11 (byte offset 0x20). Sources 32–63 use the bank at word indices 4–7 (byte offset 0x10). Within a bank the words are, in order: latched event (+0), enable (+1), acknowledge (+2), level (+3). The acknowledge word and the unused indices 1–3 and 12–15 read 0.
- R11: Clearing an enable bit removes that source from `irq_o` and from the vector. Its latched-event bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low reset |
| src_i | input | 64 | Asynchronous interrupt inputs; bit n is source n |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high together with bus_sel_i |
| bus_addr_i | input | 4 | Word index inside the 16-word window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The input path has a fixed latency. The level word follows a new input value two edges later and the latched event appears on the third edge. `irq_o` follows the latched state one edge after that. A register write lands on its own edge, and the vector and the read data follow at once because they are combinational. All inputs are driven at falling edges and all outputs are sampled at the next falling edge after the counted number of rising edges. Each check therefore asserts both that a result is not yet present one edge early and that it is present when due: request rise, request fall after an acknowledge, and an edge colliding with an acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int WADDR_W   = 4;
    localparam int VEC_W     = 8;
    localparam int IDX_W     = $clog2(NUM_SRC);

    // word offsets inside one bank
    localparam logic [1:0] OFS_EVT = 2'd0;
    localparam logic [1:0] OFS_EN  = 2'd1;
    localparam logic [1:0] OFS_ACK = 2'd2;
    localparam logic [1:0] OFS_LVL = 2'd3;

    localparam logic [WADDR_W-1:0] VEC_WORD = '0;

    // bank b sits at word 8 - 4*b (lower sources at the higher offset)
    function automatic logic [WADDR_W-1:0] bank_word_base(input int b);
        return WADDR_W'(8 - 4 * b);
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] rise_i,
    input  logic         en_wr_i,
    input  logic         ack_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] en;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [W-1:0] ack_mask;

    always_comb begin
        st_d     = st_q;
        ack_mask = ack_wr_i ? wdata_i : '0;
        // capture is gated by the enable in force this cycle;
        // a fresh edge overrides an acknowledge of the same bit
        st_d.evt = (st_q.evt & ~ack_mask) | (rise_i & st_q.en);
        if (en_wr_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign en_o  = st_q.en;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N     = 64,
    parameter int VEC_W = 8
) (
    input  logic [N-1:0]     pend_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam int IDX_W = $clog2(N);

    logic             found;
    logic [IDX_W-1:0] idx;

    // later (higher) indices overwrite earlier ones: highest wins,
    // and the upper bank occupies the upper bits
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        vec_o = '0;
        if (found) begin
            vec_o[IDX_W-1:0] = idx;
        end else begin
            vec_o[VEC_W-1] = 1'b1;
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [WADDR_W-1:0] bus_addr_i,
    input  logic [BANK_W-1:0]  bus_wdata_i,
    output logic [BANK_W-1:0]  bus_rdata_o,
    output logic               irq_o
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                 bus_wr;
    logic [NUM_SRC-1:0]   lvl_all;
    logic [NUM_SRC-1:0]   rise_all;
    logic [NUM_SRC-1:0]   ev_all;
    logic [NUM_SRC-1:0]   en_all;
    logic [NUM_SRC-1:0]   pend_all;
    logic [VEC_W-1:0]     vec;
    logic [NUM_BANKS-1:0] bank_hit;

    assign bus_wr = bus_sel_i & bus_we_i;

    irqc_sync #(
        .W      (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .level_o (lvl_all),
        .rise_o  (rise_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [WADDR_W-1:0] BASE = bank_word_base(b);
        logic hit_en;
        logic hit_ack;

        assign bank_hit[b] = (bus_addr_i[WADDR_W-1:2] == BASE[WADDR_W-1:2]);
        assign hit_en      = bus_wr & bank_hit[b] & (bus_addr_i[1:0] == OFS_EN);
        assign hit_ack     = bus_wr & bank_hit[b] & (bus_addr_i[1:0] == OFS_ACK);

        irqc_bank #(
            .W (BANK_W)
        ) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .rise_i   (rise_all[b*BANK_W +: BANK_W]),
            .en_wr_i  (hit_en),
            .ack_wr_i (hit_ack),
            .wdata_i  (bus_wdata_i),
            .evt_o    (ev_all[b*BANK_W +: BANK_W]),
            .en_o     (en_all[b*BANK_W +: BANK_W])
        );
    end

    assign pend_all = (ev_all | lvl_all) & en_all;

    irqc_prio #(
        .N     (NUM_SRC),
        .VEC_W (VEC_W)
    ) u_prio (
        .pend_i (pend_all),
        .vec_o  (vec)
    );

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == VEC_WORD) begin
            bus_rdata_o = BANK_W'(vec);
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (bus_addr_i[1:0])
                    OFS_EVT: bus_rdata_o = ev_all[b*BANK_W +: BANK_W];
                    OFS_EN:  bus_rdata_o = en_all[b*BANK_W +: BANK_W];
                    OFS_LVL: bus_rdata_o = lvl_all[b*BANK_W +: BANK_W];
                    default: bus_rdata_o = '0;
                endcase
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(ev_all & en_all);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr,
    input logic [3:0]    addr,
    input logic [31:0]   wdata,
    input logic [N-1:0]  ev,
    input logic [N-1:0]  en,
    input logic [N-1:0]  lvl,
    input logic [N-1:0]  rise,
    input logic          irq,
    input logic [7:0]    vec
);
    logic [N-1:0] pend;
    assign pend = (ev | lvl) & en;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'hA) |=> ((ev[31:0] & $past(wdata) & ~$past(rise[31:0])) == '0)); // R5

    AST_ENABLE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'h5) |=> (en[63:32] == $past(wdata))); // R6

    AST_NO_MASKED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ~$past(ev) & ~$past(en)) == '0)); // R4

    AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|$past(ev & en))); // R8

    AST_VEC_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        !vec[7] |-> ((pend >> vec[5:0]) == N'(1))); // R9

    AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        vec[7] |-> (pend == '0 && vec[6:0] == '0)); // R9
endmodule

bind banked_irq_ctrl irqc_checker #(.N(64)) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .wr    (bus_wr),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .ev    (ev_all),
    .en    (en_all),
    .lvl   (lvl_all),
    .rise  (rise_all),
    .irq   (irq_o),
    .vec   (vec)
);

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
    localparam logic [3:0] A_VEC = 4'd0;
    localparam logic [3:0] A_EV1 = 4'd4, A_EN1 = 4'd5, A_ACK1 = 4'd6, A_LV1 = 4'd7;
    localparam logic [3:0] A_EV0 = 4'd8, A_EN0 = 4'd9, A_ACK0 = 4'd10, A_LV0 = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    banked_irq_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #2;
        d = rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_EV0, v); check("R1", "event bank0", v, 0);
        bus_read(A_EN0, v); check("R1", "enable bank0", v, 0);
        bus_read(A_EV1, v); check("R1", "event bank1", v, 0);
        bus_read(A_EN1, v); check("R1", "enable bank1", v, 0);
        check("R1", "irq", 32'(irq), 0);
        bus_read(A_VEC, v); check("R1", "vector idle", v, 32'h80);
        bus_read(4'd2, v);  check("R10", "unused word 2", v, 0);
        bus_read(4'd13, v); check("R10", "unused word 13", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        src[5] = 1'b1; src[40] = 1'b1;
        edges(1);
        bus_read(A_LV0, v); check("R2", "level0 one edge early", v, 0);
        edges(1);
        bus_read(A_LV0, v); check("R2", "level0 bit5", v, 32'h20);
        bus_read(A_LV1, v); check("R2", "level1 bit8", v, 32'h100);
        edges(2);
        bus_read(A_EV0, v); check("R4", "masked edge bank0", v, 0);
        bus_read(A_EV1, v); check("R4", "masked edge bank1", v, 0);
        src[5] = 1'b0; src[40] = 1'b0;
        edges(3);
        bus_read(A_LV1, v); check("R2", "level1 back low", v, 0);
    endtask

    task automatic t_edge_ack();
        logic [31:0] v;
        bus_write(A_EN0, 32'h8);
        src[3] = 1'b1;
        edges(2);
        bus_read(A_EV0, v); check("R3", "event one edge early", v, 0);
        edges(1);
        bus_read(A_EV0, v); check("R3", "event bit3", v, 32'h8);
        check("R8", "irq not yet", 32'(irq), 0);
        edges(1);
        check("R8", "irq raised", 32'(irq), 1);
        bus_read(A_VEC, v); check("R9", "vector 3", v, 3);
        bus_write(A_ACK0, 32'h0);
        bus_read(A_EV0, v); check("R5", "ack zeros no effect", v, 32'h8);
        bus_write(A_ACK0, 32'h8);
        bus_read(A_EV0, v); check("R5", "ack clears", v, 0);
        check("R8", "irq still high on ack edge", 32'(irq), 1);
        edges(1);
        check("R8", "irq falls next edge", 32'(irq), 0);
        bus_read(A_VEC, v); check("R9", "level keeps vector 3", v, 3);
        src[3] = 1'b0;
        edges(3);
        bus_write(A_EN0, 32'h0);
    endtask

    task automatic t_masked_enable();
        logic [31:0] v;
        src[7] = 1'b1;
        edges(4);
        bus_write(A_EN0, 32'h80);
        bus_read(A_VEC, v); check("R9", "level pending vector 7", v, 7);
        edges(4);
        bus_read(A_EV0, v); check("R4", "enable while high latches nothing", v, 0);
        check("R4", "irq stays low", 32'(irq), 0);
        src[7] = 1'b0;
        edges(3);
        bus_write(A_EN0, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        bus_write(A_EV0, 32'hFFFF_FFFF);
        bus_write(A_LV1, 32'hFFFF_FFFF);
        bus_read(A_EV0, v); check("R7", "event write ignored", v, 0);
        bus_read(A_LV1, v); check("R7", "level write ignored", v, 0);
        bus_write(A_EN1, 32'hA5A5_0F0F);
        bus_read(A_EN1, v); check("R6", "enable1 readback", v, 32'hA5A5_0F0F);
        bus_read(A_ACK1, v); check("R10", "ack reads zero", v, 0);
        bus_read(A_EN0, v); check("R10", "bank0 enable untouched", v, 0);
        bus_write(A_EN1, 32'h0);
        bus_read(A_EN1, v); check("R6", "enable1 cleared", v, 0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        bus_write(A_EN0, 32'hFFFF_FFFF);
        bus_write(A_EN1, 32'hFFFF_FFFF);
        src[2] = 1'b1; src[20] = 1'b1; src[35] = 1'b1;
        edges(3);
        bus_read(A_VEC, v); check("R9", "upper bank first", v, 35);
        bus_read(A_EV1, v); check("R10", "source 35 in bank1 bit3", v, 32'h8);
        bus_write(A_EN1, 32'h0);
        bus_read(A_VEC, v); check("R11", "disabled source leaves vector", v, 20);
        bus_read(A_EV1, v); check("R11", "event kept when disabled", v, 32'h8);
        bus_write(A_ACK1, 32'hFFFF_FFFF);
        bus_read(A_EV1, v); check("R5", "ack bank1", v, 0);
        check("R8", "irq from bank0", 32'(irq), 1);
        bus_write(A_EN0, 32'h0);
        edges(1);
        check("R11", "irq drops when disabled", 32'(irq), 0);
        bus_read(A_EV0, v); check("R11", "bank0 events kept", v, 32'h0010_0004);
        bus_write(A_ACK0, 32'hFFFF_FFFF);
        src[2] = 1'b0; src[20] = 1'b0; src[35] = 1'b0;
        edges(3);
        bus_read(A_VEC, v); check("R9", "idle again", v, 32'h80);
    endtask

    task automatic t_ack_collision();
        logic [31:0] v;
        bus_write(A_EN0, 32'h200);
        src[9] = 1'b1;
        edges(2);
        bus_write(A_ACK0, 32'h200);
        bus_read(A_EV0, v); check("R5", "edge beats ack", v, 32'h200);
        bus_write(A_ACK0, 32'h200);
        bus_read(A_EV0, v); check("R5", "second ack clears", v, 0);
        src[9] = 1'b0;
        edges(3);
        bus_write(A_EN0, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_level();
        t_edge_ack();
        t_masked_enable();
        t_readonly();
        t_priority();
        t_ack_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule